// File: doc/BRIEF.md
# Edge-triggered interrupt aggregator

This block gathers a set of interrupt request lines from the rest of the chip and turns them into a single upstream interrupt for the host bridge. Every line is sampled on the system clock and a low-to-high change on it is latched as a sticky bit in a source register. Software reads that register to learn which events happened. The read returns the latched bits and clears them in the same access. A second register holds one enable bit per line. Only an edge on an enabled line raises the upstream interrupt, and that interrupt is a single-cycle high pulse. Edges on disabled lines are still latched.

The source bit for line i is bit i of the source register. The default ten lines are, from bit 0 upward: DMA transfer finished, DMA fault, carrier board too hot, mezzanine board too hot, analog input overload, acquisition trigger seen, acquisition shot complete, identification-memory I2C access finished, clock-synthesizer I2C access finished, and converter configuration access finished. The top bit of the source register is a debug flag. It records that some line produced an edge while its bit was still set from an earlier edge. The register port is a simple single-cycle read/write strobe interface. Read data is combinational on the address.

Top module: `irq_edge_collector`

## Requirements
- R1: A rising edge on irq_in[i] (the input low in one clock cycle and high in the next) sets bit i of the source register at that clock edge. A line held high sets the bit only once.
- R2: A read strobe (reg_rd) at address 0x0083 returns the source register on reg_rdata in the same cycle: bits [NSRC-1:0] are the sources and bit 31 is the repeat flag. At the end of that cycle all of these bits are cleared.
- R3: If a rising edge lands in the same cycle as a read of the source register, the read returns the value from before that edge. The edge's bit is still set after the clear and is not lost.
- R4: An edge on a line whose enable bit is 0 sets its source bit but produces no pulse on irq_pulse.
- R5: irq_pulse goes high for exactly one cycle, in the cycle after each clock edge at which at least one enabled line rose. Edges on several enabled lines in the same cycle give one pulse. Edges in consecutive cycles give separate pulses.
- R6: The enable register is at address 0x0084. A write strobe (reg_wr) there loads reg_wdata, and reading it returns the written bits in [NSRC-1:0]. The enable register, the source register and the repeat flag all reset to 0.
- R7: An edge on a line whose source bit is already set sets bit 31 of the source register. This applies to disabled lines too. Bit 31 is cleared by a read of the source register.
- R8: Bits [30:NSRC] of the source register and bits [31:NSRC] of the enable register read as 0. Any other address reads 0. A write to address 0x0083 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | NSRC | Interrupt request lines, synchronous to clk |
| reg_addr | input | ADDR_W | Register address |
| reg_rd | input | 1 | Read strobe, one cycle per access |
| reg_wr | input | 1 | Write strobe, one cycle per access |
| reg_wdata | input | NSRC | Write data for the enable register |
| reg_rdata | output | DATA_W | Read data, valid in the cycle of the strobe |
| irq_pulse | output | 1 | Single-cycle upstream interrupt |

## Verification
A read of the source register and a new edge on a line can land in the same clock cycle. The clear from the read must then not erase the new bit. The bench creates this by raising one input in the exact cycle that its read strobe is high. It then checks that this read reports only the bits from before the edge, and that the next read reports the new bit alone with the repeat flag clear. The same overlap applies to the repeat flag: an edge on a bit during its clearing read counts as a fresh event, not as a repeat.

// File: rtl/irq_edge_collector.sv
module irq_edge_collector #(
  parameter int NSRC = 10,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] SRC_ADDR = 16'h0083,
  parameter logic [ADDR_W-1:0] EN_ADDR = 16'h0084
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   irq_in,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_rd,
  input  logic              reg_wr,
  input  logic [NSRC-1:0]   reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq_pulse
);
  localparam int FLAG_BIT = DATA_W - 1;

  logic [NSRC-1:0] prev_q, src_q, en_q;
  logic ovf_q, pulse_q;

  wire [NSRC-1:0] rise   = irq_in & ~prev_q;
  wire            rd_src = reg_rd && (reg_addr == SRC_ADDR);
  wire            wr_en  = reg_wr && (reg_addr == EN_ADDR);
  wire [NSRC-1:0] kept   = rd_src ? '0 : src_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q  <= '0;
      src_q   <= '0;
      en_q    <= '0;
      ovf_q   <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      prev_q  <= irq_in;
      src_q   <= kept | rise;
      ovf_q   <= (ovf_q && !rd_src) || (|(rise & kept));
      pulse_q <= |(rise & en_q);
      if (wr_en) en_q <= reg_wdata;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == SRC_ADDR) begin
      reg_rdata[NSRC-1:0] = src_q;
      reg_rdata[FLAG_BIT] = ovf_q;
    end else if (reg_addr == EN_ADDR) begin
      reg_rdata[NSRC-1:0] = en_q;
    end
  end

  assign irq_pulse = pulse_q;
endmodule

// File: rtl/irq_edge_collector_chk.sv
module irq_edge_collector_chk #(
  parameter int NSRC = 10,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] SRC_ADDR = 16'h0083
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NSRC-1:0]   irq_in,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_rd,
  input logic [DATA_W-1:0] reg_rdata,
  input logic              irq_pulse,
  input logic [NSRC-1:0]   prev_q,
  input logic [NSRC-1:0]   src_q,
  input logic [NSRC-1:0]   en_q,
  input logic              ovf_q
);
  localparam logic [DATA_W-1:0] ONES = '1;
  localparam logic [DATA_W-1:0] UPPER_MASK = (ONES >> 1) & ~(ONES >> (DATA_W - NSRC));

  wire [NSRC-1:0] seen = irq_in & ~prev_q;
  wire read_src = reg_rd && (reg_addr == SRC_ADDR);

  assert_edge_kept_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (|seen) |=> ((src_q & $past(seen)) == $past(seen)));

  assert_clear_on_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (read_src && !(|seen)) |=> (src_q == '0 && !ovf_q));

  assert_pulse_needs_enabled_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> $past(|(seen & en_q)));

  assert_pulse_single_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pulse && !(|(seen & en_q))) |=> !irq_pulse);

  assert_repeat_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((|(seen & src_q)) && !read_src) |=> ovf_q);

  assert_upper_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata & UPPER_MASK) == '0);
endmodule

bind irq_edge_collector irq_edge_collector_chk #(
  .NSRC(NSRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SRC_ADDR(SRC_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_addr(reg_addr),
  .reg_rd(reg_rd), .reg_rdata(reg_rdata), .irq_pulse(irq_pulse),
  .prev_q(prev_q), .src_q(src_q), .en_q(en_q), .ovf_q(ovf_q)
);

// File: tb/sim_irq_edge_collector.sv
`timescale 1ns/1ps
module sim_irq_edge_collector;
  localparam logic [15:0] SRC = 16'h0083;
  localparam logic [15:0] EN  = 16'h0084;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [9:0] irq_in = '0;
  logic [15:0] reg_addr = '0;
  logic reg_rd = 1'b0, reg_wr = 1'b0;
  logic [9:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic irq_pulse;

  int checks = 0, errors = 0, pulses = 0;
  bit done = 0;

  always #4 clk = ~clk;

  irq_edge_collector u0 (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_addr(reg_addr),
    .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_pulse(irq_pulse)
  );

  always @(negedge clk) if (rst_n && irq_pulse) pulses++;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd_reg(input logic [15:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic wr_reg(input logic [15:0] a, input logic [9:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic set_in(input logic [9:0] v);
    @(negedge clk);
    irq_in = v;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    #1 check("R6 pulse after reset", {31'd0, irq_pulse}, 32'd0);
    rd_reg(SRC, d); check("R6 source reset", d, 32'd0);
    rd_reg(EN, d);  check("R6 enable reset", d, 32'd0);
  endtask

  task automatic t_enable_rw;
    logic [31:0] d;
    wr_reg(EN, 10'h3FF); rd_reg(EN, d); check("R6 enable all", d, 32'h3FF);
    wr_reg(EN, 10'h00D); rd_reg(EN, d); check("R6 enable readback", d, 32'h00D);
  endtask

  task automatic t_enabled_held;
    logic [31:0] d;
    int p0 = pulses;
    set_in(10'h001);
    repeat (6) @(negedge clk);
    #1 check("R5 held line gives one pulse", pulses - p0, 1);
    rd_reg(SRC, d); check("R1 source bit 0 set", d, 32'h1);
    rd_reg(SRC, d); check("R2 cleared after read", d, 32'h0);
    set_in(10'h000);
  endtask

  task automatic t_disabled;
    logic [31:0] d;
    int p0 = pulses;
    set_in(10'h002);
    repeat (3) @(negedge clk);
    #1 check("R4 no pulse for disabled line", pulses - p0, 0);
    rd_reg(SRC, d); check("R4 disabled line still latched", d, 32'h2);
    set_in(10'h000);
  endtask

  task automatic t_simultaneous;
    logic [31:0] d;
    int p0 = pulses;
    set_in(10'h005);
    repeat (3) @(negedge clk);
    #1 check("R5 simultaneous edges one pulse", pulses - p0, 1);
    rd_reg(SRC, d); check("R1 both bits set", d, 32'h5);
    set_in(10'h000);
  endtask

  task automatic t_repeat;
    logic [31:0] d;
    int p0;
    @(negedge clk);
    p0 = pulses;
    set_in(10'h001); set_in(10'h000); set_in(10'h001);
    repeat (2) @(negedge clk);
    #1 check("R5 two edges two pulses", pulses - p0, 2);
    rd_reg(SRC, d); check("R7 repeat flag on enabled line", d, 32'h8000_0001);
    rd_reg(SRC, d); check("R7 repeat flag cleared by read", d, 32'h0);
    set_in(10'h000);
    set_in(10'h002); set_in(10'h000); set_in(10'h002);
    @(negedge clk);
    rd_reg(SRC, d); check("R7 repeat flag on disabled line", d, 32'h8000_0002);
    set_in(10'h000);
  endtask

  task automatic t_race;
    logic [31:0] d;
    set_in(10'h002);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = SRC; irq_in = 10'h00A;
    #1 d = reg_rdata;
    check("R3 read during edge returns old value", d, 32'h2);
    @(negedge clk);
    reg_rd = 1'b0;
    rd_reg(SRC, d); check("R3 edge during read survives", d, 32'h8);
    set_in(10'h000);
  endtask

  task automatic t_misc;
    logic [31:0] d;
    set_in(10'h004);
    set_in(10'h000);
    wr_reg(SRC, 10'h3FF);
    rd_reg(SRC, d); check("R8 write to source ignored", d, 32'h4);
    rd_reg(16'h0085, d); check("R8 unmapped address reads 0", d, 32'h0);
    rd_reg(EN, d); check("R8 enable unchanged, upper zero", d, 32'h00D);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_enable_rw();
    t_enabled_held();
    t_disabled();
    t_simultaneous();
    t_repeat();
    t_race();
    t_misc();
    repeat (2) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule